// File: doc/BRIEF.md
# Call and Return Stack Engine

This block carries out the stack half of subroutine calls, subroutine returns and interrupt returns for an 8-bit microcontroller core. It owns the 8-bit stack pointer and drives a byte-wide internal RAM port with at most one access per cycle. A call stores a 16-bit return address on the stack and delivers the new program counter. A return or interrupt return takes a 16-bit address off the stack and delivers it as the new program counter.

The core issues a one-cycle start together with an operation code, the return address, and the call target or the 3-bit page field taken from the opcode. The block reports done for one cycle with the new program counter and the stack-pointer values from before and after the operation. An interrupt-entry call counts an active interrupt level. An interrupt return raises a one-cycle flag and, if a level is active, a release pulse that frees that level.

Top module: `call_ret_stack`

## Requirements
- R1: After reset the stack pointer is 0x07, sp_before_o and sp_after_o read 0x07, pc_o is 0, and done_o, reti_o, lvl_release_o, ram_we_o and ram_re_o are low.
- R2: A call (op_i 0, 1 or 4) makes two writes on consecutive cycles starting the cycle after start. The first writes the return-address low byte at SP+1 and the second writes the high byte at SP+2. ram_re_o stays low throughout.
- R3: For a long call (op_i 0) or an interrupt-entry call (op_i 4), done_o is high for one cycle, three cycles after the start edge, with pc_o equal to target_i.
- R4: For an absolute-page call (op_i 1), pc_o at done is {ret_pc_i[15:11], page_i[2:0], target_i[7:0]}.
- R5: A return (op_i 2) reads at SP and then at SP-1 on the two cycles after start. It idles one cycle and then asserts done_o, four cycles after the start edge, with pc_o = {byte at SP, byte at SP-1}. The stack pointer ends at SP-2.
- R6: The stack pointer is 8 bits wide and wraps from 0xFF to 0x00 on increment and from 0x00 to 0xFF on decrement, for both addresses and reported values.
- R7: At done, sp_before_o holds the pointer at start and sp_after_o holds the pointer after the operation. Both hold their values until the next operation completes.
- R8: An interrupt return (op_i 3) performs the same reads and timing as a return, and reti_o is high exactly in the done cycle.
- R9: Each completed interrupt-entry call raises the active-level count, which saturates at 3. An interrupt return asserts lvl_release_o in its done cycle only when the count is nonzero, and then lowers the count by one.
- R10: A start that arrives while an operation is in progress, including its done cycle, is ignored.
- R11: The op_i codes 5, 6 and 7 start nothing: no RAM access, no done, and the stack pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command, one cycle |
| op_i | input | 3 | 0 long call, 1 page call, 2 return, 3 interrupt return, 4 interrupt entry |
| ret_pc_i | input | 16 | Return address to push |
| target_i | input | 16 | Call target or interrupt vector; low byte for page call |
| page_i | input | 3 | Page field from opcode bits 7:5 |
| ram_rdata_i | input | 8 | RAM read data, one cycle after ram_re_o |
| ram_addr_o | output | 8 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| pc_o | output | 16 | New program counter, valid with done_o |
| done_o | output | 1 | Operation complete, one cycle |
| sp_before_o | output | 8 | Stack pointer at start |
| sp_after_o | output | 8 | Stack pointer at completion |
| reti_o | output | 1 | Interrupt return completed |
| lvl_release_o | output | 1 | Release the active interrupt level |

## Verification
The hardest conditions to reach are pointer wrap across 0xFF/0x00 and level release when no level is active. Wrap needs more than a hundred back-to-back calls. The stimulus therefore runs a long call chain until the pushes straddle the top of the pointer range, then returns through the same addresses, so that both increment and decrement cross the boundary. Release gating is reached by issuing interrupt returns before any interrupt entry, then after entries that exceed the saturation count. Starts are also driven during every busy phase and with unused codes, and the reference model shows that they change nothing.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_LCALL   = 3'd0,
    OP_PCALL   = 3'd1,
    OP_RET     = 3'd2,
    OP_RETI    = 3'd3,
    OP_INTCALL = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_HI,
    ST_POP_LO,
    ST_CAP,
    ST_FIN
  } st_e;
endpackage

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] RST_VAL = AW'(7)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [AW-1:0] sp_o
);
  logic [AW-1:0] sp_q;

  // natural modulo wrap in both directions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sp_q <= RST_VAL;
    else if (inc_i) sp_q <= sp_q + AW'(1);
    else if (dec_i) sp_q <= sp_q - AW'(1);
  end

  assign sp_o = sp_q;
endmodule

// File: rtl/stk_lvl_track.sv
module stk_lvl_track #(
  parameter int unsigned LVL_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic leave_i,
  output logic active_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
  logic [LVL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (enter_i && cnt_q != LVL_MAX) cnt_q <= cnt_q + LVL_W'(1);
    else if (leave_i && cnt_q != '0)      cnt_q <= cnt_q - LVL_W'(1);
  end

  assign active_o = |cnt_q;
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned PG_W = 3,
  parameter logic [DW-1:0] SP_RST = DW'(7)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [2*DW-1:0] ret_pc_i,
  input  logic [2*DW-1:0] target_i,
  input  logic [PG_W-1:0] page_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [DW-1:0] sp_i,
  input  logic          lvl_active_i,
  output logic [DW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_we_o,
  output logic          ram_re_o,
  output logic          sp_inc_o,
  output logic          sp_dec_o,
  output logic [2*DW-1:0] pc_o,
  output logic          done_o,
  output logic [DW-1:0] sp_before_o,
  output logic [DW-1:0] sp_after_o,
  output logic          reti_o,
  output logic          lvl_release_o,
  output logic          lvl_enter_o
);
  localparam int unsigned PC_W = 2 * DW;
  localparam int unsigned HI_W = PC_W - DW - PG_W;

  st_e             st_q;
  op_e             op_q;
  logic [PC_W-1:0] ret_q, tgt_q, pc_q;
  logic [DW-1:0]   hi_q, spb_q, spa_q;
  logic            op_ok, is_call;
  logic [PC_W-1:0] tgt_sel;

  assign op_ok   = (op_i <= 3'd4);
  assign is_call = (op_i == OP_LCALL) || (op_i == OP_PCALL) || (op_i == OP_INTCALL);
  // page call keeps upper return bits, page field replaces the next three
  assign tgt_sel = (op_i == OP_PCALL) ?
                   {ret_pc_i[PC_W-1 -: HI_W], page_i, target_i[DW-1:0]} : target_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      op_q  <= OP_LCALL;
      ret_q <= '0;
      tgt_q <= '0;
      pc_q  <= '0;
      hi_q  <= '0;
      spb_q <= SP_RST;
      spa_q <= SP_RST;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i && op_ok) begin
          op_q  <= op_e'(op_i);
          ret_q <= ret_pc_i;
          tgt_q <= tgt_sel;
          st_q  <= is_call ? ST_PUSH_LO : ST_POP_HI;
        end
        ST_PUSH_LO: st_q <= ST_PUSH_HI;
        ST_PUSH_HI: begin
          pc_q  <= tgt_q;
          spb_q <= sp_i - DW'(1);
          spa_q <= sp_i + DW'(1);
          st_q  <= ST_FIN;
        end
        ST_POP_HI: st_q <= ST_POP_LO;
        ST_POP_LO: begin
          hi_q <= ram_rdata_i;
          st_q <= ST_CAP;
        end
        ST_CAP: begin
          pc_q  <= {hi_q, ram_rdata_i};
          spb_q <= sp_i + DW'(2);
          spa_q <= sp_i;
          st_q  <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ram_addr_o  = '0;
    ram_wdata_o = '0;
    ram_we_o    = 1'b0;
    ram_re_o    = 1'b0;
    sp_inc_o    = 1'b0;
    sp_dec_o    = 1'b0;
    unique case (st_q)
      ST_PUSH_LO: begin
        ram_addr_o  = sp_i + DW'(1);
        ram_wdata_o = ret_q[DW-1:0];
        ram_we_o    = 1'b1;
        sp_inc_o    = 1'b1;
      end
      ST_PUSH_HI: begin
        ram_addr_o  = sp_i + DW'(1);
        ram_wdata_o = ret_q[PC_W-1:DW];
        ram_we_o    = 1'b1;
        sp_inc_o    = 1'b1;
      end
      ST_POP_HI, ST_POP_LO: begin
        ram_addr_o = sp_i;
        ram_re_o   = 1'b1;
        sp_dec_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign done_o        = (st_q == ST_FIN);
  assign reti_o        = done_o && (op_q == OP_RETI);
  assign lvl_release_o = reti_o && lvl_active_i;
  assign lvl_enter_o   = done_o && (op_q == OP_INTCALL);
  assign pc_o          = pc_q;
  assign sp_before_o   = spb_q;
  assign sp_after_o    = spa_q;
endmodule

// File: rtl/call_ret_stack.sv
module call_ret_stack #(
  parameter int unsigned DW    = 8,
  parameter int unsigned PG_W  = 3,
  parameter int unsigned LVL_W = 2,
  parameter logic [DW-1:0] SP_RST = DW'(7)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [2*DW-1:0] ret_pc_i,
  input  logic [2*DW-1:0] target_i,
  input  logic [PG_W-1:0] page_i,
  input  logic [DW-1:0]   ram_rdata_i,
  output logic [DW-1:0]   ram_addr_o,
  output logic [DW-1:0]   ram_wdata_o,
  output logic            ram_we_o,
  output logic            ram_re_o,
  output logic [2*DW-1:0] pc_o,
  output logic            done_o,
  output logic [DW-1:0]   sp_before_o,
  output logic [DW-1:0]   sp_after_o,
  output logic            reti_o,
  output logic            lvl_release_o
);
  logic [DW-1:0] sp_w;
  logic          sp_inc, sp_dec, lvl_active, lvl_enter;

  stk_sp_reg #(.AW(DW), .RST_VAL(SP_RST)) u_sp (
    .clk_i, .rst_ni, .inc_i(sp_inc), .dec_i(sp_dec), .sp_o(sp_w)
  );

  stk_lvl_track #(.LVL_W(LVL_W)) u_lvl (
    .clk_i, .rst_ni, .enter_i(lvl_enter), .leave_i(lvl_release_o),
    .active_o(lvl_active)
  );

  stk_ctrl #(.DW(DW), .PG_W(PG_W), .SP_RST(SP_RST)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .op_i, .ret_pc_i, .target_i, .page_i,
    .ram_rdata_i, .sp_i(sp_w), .lvl_active_i(lvl_active),
    .ram_addr_o, .ram_wdata_o, .ram_we_o, .ram_re_o,
    .sp_inc_o(sp_inc), .sp_dec_o(sp_dec),
    .pc_o, .done_o, .sp_before_o, .sp_after_o, .reti_o, .lvl_release_o,
    .lvl_enter_o(lvl_enter)
  );
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ram_we_o,
  input logic          ram_re_o,
  input logic [DW-1:0] ram_addr_o,
  input logic          done_o,
  input logic          reti_o,
  input logic          lvl_release_o,
  input logic [DW-1:0] sp_w
);
  // R2
  we_re_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o));

  // R2
  push_preinc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> sp_w == $past(ram_addr_o));

  // R5
  pop_postdec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_re_o |=> sp_w == DW'($past(ram_addr_o) - DW'(1)));

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  reti_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_o |-> done_o);

  // R9
  release_on_reti_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_release_o |-> reti_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ram_we_o && !ram_re_o);
endmodule

bind call_ret_stack stk_engine_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
  .ram_addr_o(ram_addr_o), .done_o(done_o), .reti_o(reti_o),
  .lvl_release_o(lvl_release_o), .sp_w(sp_w)
);

// File: tb/sim_call_ret_stack.sv
module sim_call_ret_stack;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit       we, re, done, reti, rel;
    bit [7:0] addr, wdata, spb, spa;
    bit [15:0] pc;
  } exp_t;

  logic        clk = 0, rst_n = 0;
  logic        start = 0;
  logic [2:0]  op = 0, page = 0;
  logic [15:0] ret_pc = 0, target = 0;
  logic [7:0]  rdata = 0;
  logic [7:0]  addr, wdata, spb, spa;
  logic        we, re, done, reti, rel;
  logic [15:0] pc;

  int total = 0, bad = 0, cyc = 0;
  bit [7:0] tb_mem [256];
  bit [7:0] m_mem  [256];
  exp_t q [$];
  bit [7:0] m_sp = 8'h07;
  int m_lvl = 0;
  bit [15:0] last_pc = 0;
  bit [7:0]  last_spb = 8'h07, last_spa = 8'h07;

  call_ret_stack u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .ret_pc_i(ret_pc), .target_i(target), .page_i(page), .ram_rdata_i(rdata),
    .ram_addr_o(addr), .ram_wdata_o(wdata), .ram_we_o(we), .ram_re_o(re),
    .pc_o(pc), .done_o(done), .sp_before_o(spb), .sp_after_o(spa),
    .reti_o(reti), .lvl_release_o(rel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (we) tb_mem[addr] <= wdata;
    if (re) rdata <= tb_mem[addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp_v);
    end
  endtask

  // one negedge: compare against model, then drive inputs
  task automatic step(bit st, bit [2:0] o, bit [15:0] rp, bit [15:0] tg, bit [2:0] pg);
    exp_t e;
    bit idle;
    @(negedge clk);
    idle = (q.size() == 0);
    e = '{default: 0};
    if (!idle) e = q.pop_front();
    chk(we == e.we, "R2 we", we, e.we);
    chk(re == e.re, "R5 re", re, e.re);
    if (e.we) begin
      chk(addr == e.addr, "R2/R6 waddr", addr, e.addr);
      chk(wdata == e.wdata, "R2 wdata", wdata, e.wdata);
    end
    if (e.re) chk(addr == e.addr, "R5/R6 raddr", addr, e.addr);
    chk(done == e.done, "R3/R10/R11 done", done, e.done);
    chk(reti == e.reti, "R8 reti", reti, e.reti);
    chk(rel == e.rel, "R9 release", rel, e.rel);
    if (e.done) begin
      last_pc = e.pc; last_spb = e.spb; last_spa = e.spa;
    end
    chk(pc == last_pc, "R3/R4/R5 pc", pc, last_pc);
    chk(spb == last_spb, "R7 sp_before", spb, last_spb);
    chk(spa == last_spa, "R6/R7 sp_after", spa, last_spa);
    start = st; op = o; ret_pc = rp; target = tg; page = pg;
    if (st && idle && o <= 3'd4) begin
      bit [7:0] s = m_sp;
      if (o == 3'd2 || o == 3'd3) begin
        bit [7:0] a1 = s, a2 = s - 8'd1;
        exp_t r1 = '{default: 0}, r2 = '{default: 0}, w = '{default: 0}, d = '{default: 0};
        r1.re = 1; r1.addr = a1;
        r2.re = 1; r2.addr = a2;
        d.done = 1; d.pc = {m_mem[a1], m_mem[a2]};
        d.spb = s; d.spa = s - 8'd2;
        d.reti = (o == 3'd3);
        d.rel = d.reti && m_lvl > 0;
        if (d.rel) m_lvl--;
        q.push_back(r1); q.push_back(r2); q.push_back(w); q.push_back(d);
        m_sp = s - 8'd2;
      end else begin
        bit [7:0] a1 = s + 8'd1, a2 = s + 8'd2;
        exp_t w1 = '{default: 0}, w2 = '{default: 0}, d = '{default: 0};
        w1.we = 1; w1.addr = a1; w1.wdata = rp[7:0];
        w2.we = 1; w2.addr = a2; w2.wdata = rp[15:8];
        m_mem[a1] = rp[7:0]; m_mem[a2] = rp[15:8];
        d.done = 1; d.spb = s; d.spa = a2;
        d.pc = (o == 3'd1) ? {rp[15:11], pg, tg[7:0]} : tg;
        if (o == 3'd4 && m_lvl < 3) m_lvl++;
        q.push_back(w1); q.push_back(w2); q.push_back(d);
        m_sp = a2;
      end
    end
  endtask

  task automatic run(bit [2:0] o, bit [15:0] rp, bit [15:0] tg, bit [2:0] pg);
    step(1, o, rp, tg, pg);
    while (q.size() > 0) step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    bit [15:0] lcg;
    for (int i = 0; i < 256; i++) begin
      tb_mem[i] = 8'(i * 7 + 3);
      m_mem[i]  = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spb == 8'h07 && spa == 8'h07, "R1 sp", {spb, spa}, 16'h0707);
    chk(pc == 16'h0, "R1 pc", pc, 0);
    chk(!done && !we && !re && !reti && !rel, "R1 idle", {done, we, re, reti, rel}, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0);

    run(3'd0, 16'h1234, 16'h5678, 0);          // R2 R3 long call
    run(3'd2, 0, 0, 0);                         // R5 return
    run(3'd1, 16'hABCD, 16'h0042, 3'b101);      // R4 page call -> AD42
    // R10 starts during busy
    step(1, 3'd0, 16'h1111, 16'h2222, 0);
    for (int k = 0; k < 5; k++) step(1, 3'(k % 5), 16'h9999, 16'h8888, 3'd7);
    step(0, 0, 0, 0, 0);
    run(3'd2, 0, 0, 0);
    run(3'd2, 0, 0, 0);
    // R11 unused codes
    for (int c = 5; c < 8; c++) begin
      step(1, 3'(c), 16'hFFFF, 16'hEEEE, 0);
      repeat (4) step(0, 0, 0, 0, 0);
    end
    run(3'd0, 16'h0F0F, 16'h1000, 0);           // R7 shows unchanged pointer
    // R8 R9 interrupt return with no level active
    run(3'd3, 0, 0, 0);
    // R9 entries beyond saturation, then returns
    for (int k = 0; k < 4; k++) run(3'd4, 16'h3000 + 16'(k), 16'h0003 + 16'(k * 8), 0);
    for (int k = 0; k < 4; k++) run(3'd3, 0, 0, 0);
    // R6 wrap: long chain of calls across 0xFF, then back
    for (int k = 0; k < 130; k++) run(3'd0, 16'(16'h4000 + k * 3), 16'(k), 0);
    for (int k = 0; k < 130; k++) run(3'd2, 0, 0, 0);
    // mixed pattern
    lcg = 16'hACE1;
    for (int k = 0; k < 60; k++) begin
      lcg = lcg * 16'd25173 + 16'd13849;
      run(3'(lcg[14:12] % 5), lcg, ~lcg, lcg[2:0]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule